// File: doc/BRIEF.md
# SDRAM Command and Refresh Controller

This block sits between a host and a four-bank synchronous DRAM. The host hands it one access at a time over a valid/ready channel. Each access carries a bank, a 12-bit row, a 10-bit column, a read/write flag, an auto-precharge request and a byte mask. The controller turns each access into commands on the chip-select, RAS, CAS and WE lines. It puts the row and then the column on one shared address bus and keeps track of which row is open in each bank. It also inserts an auto-refresh at a fixed interval.

After reset the controller waits through a power-up delay. It then precharges all banks, issues two refreshes and writes the mode register with the read latency and burst length. Only after that does it raise `init_done` and start taking host requests. For every read it pulses `rd_valid` when the first data beat is due at the device pins.

Back-pressure works as follows. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. The host must hold every request field stable while `req_valid` is high and `req_ready` is low. `req_ready` is high only when the controller is idle, has finished its post-command waits, is initialised and has no refresh pending.

Top module: `sdram_cmd_ctrl`

## Requirements
- R1: While reset is held, the command lines show a deselect (`sd_cs_n` high), and `req_ready`, `init_done`, `rd_valid` and `sd_dqm` are all low.
- R2: After the power-up delay the controller issues these commands in order: precharge-all, refresh after tRP, refresh after tRC, mode write after tRC. `init_done` rises exactly tMRD cycles after the mode write, and no mode write is issued after that.
- R3: The mode word on the address bus has the burst-length code in bits 2..0 (1→0, 2→1, 4→2, 8→3), 0 (sequential) in bit 3, the read latency in bits 6..4, and zeros in all higher bits.
- R4: Commands use chip select low plus {RAS,CAS,WE}: NOP 111, ACTIVE 011, READ 101, WRITE 100, PRECHARGE 010, REFRESH 001, MODE 000. No other code is ever driven.
- R5: An access to a bank with no open row issues ACTIVE (bank on `sd_ba`, row on `sd_addr`). The column command follows exactly tRCD cycles later, with the column on bits 9..0, the auto-precharge flag on bit 10 and bit 11 zero.
- R6: An access to a bank whose open row equals the requested row issues the column command with no ACTIVE and no PRECHARGE first.
- R7: An access to a bank holding a different row first issues PRECHARGE for that bank alone (bit 10 low). ACTIVE follows exactly tRP cycles later.
- R8: A refresh request is raised every REFI cycles. When idle it takes priority over a waiting host request. Open banks are closed by a precharge-all with bit 10 high exactly tRP before the REFRESH. No command follows a REFRESH within tRC cycles.
- R9: `rd_valid` pulses for one cycle exactly CAS_LAT cycles after each READ and at no other time.
- R10: Accepted requests are served in acceptance order, each exactly once, and `req_ready` stays low until `init_done` is high.
- R11: `sd_dqm` carries the request's mask bit during its WRITE command and is low during every other command.
- R12: After a READ or WRITE, the next command comes no sooner than BURST_LEN+tRP cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every output changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller takes the request on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_autopre | input | 1 | Close the row after this access |
| req_mask | input | 1 | Byte mask driven with the write |
| req_bank | input | 2 | Target bank |
| req_row | input | 12 | Target row |
| req_col | input | 10 | Target column |
| rd_valid | output | 1 | First read beat due at the device |
| init_done | output | 1 | Power-up programming finished |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe |
| sd_cas_n | output | 1 | Column strobe |
| sd_we_n | output | 1 | Write enable |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | 12 | Shared row/column/mode address |
| sd_dqm | output | 1 | Data mask |

## Verification
A refresh request and a host request can both be ready to start in the same idle cycle. To provoke this, the bench keeps `req_valid` high back to back through a long random run, so each interval expiry lands on a cycle where a request is waiting. The bench checks that the precharge-all and REFRESH appear before the waiting column command. It also checks that the gap between refreshes never exceeds REFI plus the longest access. Finally, it checks that the held request is still served later, in order and with its own fields.

// File: rtl/sdram_ctrl_pkg.sv
package sdram_ctrl_pkg;
  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_DESEL = 4'b1111;
  localparam logic [3:0] CMD_NOP   = 4'b0111;
  localparam logic [3:0] CMD_ACT   = 4'b0011;
  localparam logic [3:0] CMD_RD    = 4'b0101;
  localparam logic [3:0] CMD_WR    = 4'b0100;
  localparam logic [3:0] CMD_PRE   = 4'b0010;
  localparam logic [3:0] CMD_REF   = 4'b0001;
  localparam logic [3:0] CMD_MODE  = 4'b0000;

  typedef enum logic [3:0] {
    ST_PWRUP, ST_IREF1, ST_IREF2, ST_IMODE, ST_IEND,
    ST_IDLE, ST_ACT, ST_COL, ST_REF
  } ctrl_state_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic [2:0] burst_code(input int len);
    case (len)
      2:       return 3'd1;
      4:       return 3'd2;
      8:       return 3'd3;
      default: return 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
  parameter int REFI = 1562
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic ack,
  output logic pending
);
  localparam int CW = $clog2(REFI + 1);
  localparam logic [CW-1:0] RELOAD = CW'(REFI - 1);

  logic [CW-1:0] cnt_q;
  logic          expire;

  assign expire = run && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= RELOAD;
      pending <= 1'b0;
    end else begin
      if (!run || expire) cnt_q <= RELOAD;
      else                cnt_q <= cnt_q - 1'b1;
      pending <= expire | (pending & ~ack);
    end
  end
endmodule

// File: rtl/sdram_bank_track.sv
module sdram_bank_track #(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act,
  input  logic              pre_one,
  input  logic              pre_all,
  input  logic              close,
  input  logic [BANK_W-1:0] ba,
  input  logic [ROW_W-1:0]  row,
  output logic              any_open,
  output logic              cur_open,
  output logic              cur_hit
);
  localparam int NBANK = 1 << BANK_W;

  logic [NBANK-1:0] open_q;
  logic [ROW_W-1:0] row_q [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        open_q[b] <= 1'b0;
        row_q[b]  <= '0;
      end else if (pre_all) begin
        open_q[b] <= 1'b0;
      end else if (ba == BANK_W'(b)) begin
        if (act) begin
          open_q[b] <= 1'b1;
          row_q[b]  <= row;
        end else if (pre_one || close) begin
          open_q[b] <= 1'b0;
        end
      end
    end
  end

  assign any_open = |open_q;
  assign cur_open = open_q[ba];
  assign cur_hit  = open_q[ba] && (row_q[ba] == row);
endmodule

// File: rtl/sdram_rd_pipe.sv
module sdram_rd_pipe #(
  parameter int LAT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic issue,
  output logic strobe
);
  logic [LAT:0] pipe_q;

  always_ff @(posedge clk) begin
    if (!rst_n) pipe_q[0] <= 1'b0;
    else        pipe_q[0] <= issue;
  end

  for (genvar i = 1; i <= LAT; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) pipe_q[i] <= 1'b0;
      else        pipe_q[i] <= pipe_q[i-1];
    end
  end

  assign strobe = pipe_q[LAT];
endmodule

// File: rtl/sdram_cmd_ctrl.sv
module sdram_cmd_ctrl
  import sdram_ctrl_pkg::*;
#(
  parameter int BANK_W    = 2,
  parameter int ROW_W     = 12,
  parameter int COL_W     = 10,
  parameter int AP_BIT    = 10,
  parameter int CAS_LAT   = 3,
  parameter int BURST_LEN = 4,
  parameter int T_RCD     = 2,
  parameter int T_RP      = 2,
  parameter int T_RC      = 7,
  parameter int T_MRD     = 2,
  parameter int INIT_CYC  = 20000,
  parameter int REFI      = 1562
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_autopre,
  input  logic              req_mask,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  output logic              rd_valid,
  output logic              init_done,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BANK_W-1:0] sd_ba,
  output logic [ROW_W-1:0]  sd_addr,
  output logic              sd_dqm
);
  localparam int COL_GAP  = BURST_LEN + T_RP;
  localparam int WAIT_MAX = imax(imax(INIT_CYC, T_RC),
                                 imax(COL_GAP, imax(T_RCD, imax(T_RP, T_MRD))));
  localparam int WAIT_W   = $clog2(WAIT_MAX + 1);
  localparam logic [ROW_W-1:0] MODE_WORD =
    ROW_W'({3'(CAS_LAT), 1'b0, burst_code(BURST_LEN)});

  ctrl_state_t state_q, state_d;
  logic [WAIT_W-1:0] wait_q, wait_d;
  logic [3:0]        cmd_q, cmd_d;
  logic [BANK_W-1:0] ba_q, ba_d;
  logic [ROW_W-1:0]  addr_q, addr_d;
  logic              dqm_q, dqm_d;
  logic              init_q, init_set;

  logic [BANK_W-1:0] lat_bank_q;
  logic [ROW_W-1:0]  lat_row_q;
  logic [COL_W-1:0]  lat_col_q;
  logic              lat_write_q, lat_ap_q, lat_mask_q;

  logic [BANK_W-1:0] cur_bank;
  logic [ROW_W-1:0]  cur_row;
  logic [COL_W-1:0]  cur_col;
  logic              cur_write, cur_ap, cur_mask;

  logic accept, ref_ack, ref_pending;
  logic trk_act, trk_pre_one, trk_pre_all, trk_close;
  logic any_open, cur_open, cur_hit;

  // Request fields come straight from the port while idle, else from the latch
  always_comb begin
    if (state_q == ST_IDLE) begin
      cur_bank  = req_bank;    cur_row = req_row;     cur_col  = req_col;
      cur_write = req_write;   cur_ap  = req_autopre; cur_mask = req_mask;
    end else begin
      cur_bank  = lat_bank_q;  cur_row = lat_row_q;   cur_col  = lat_col_q;
      cur_write = lat_write_q; cur_ap  = lat_ap_q;    cur_mask = lat_mask_q;
    end
  end

  sdram_refresh_timer #(.REFI(REFI)) u_refresh (
    .clk(clk), .rst_n(rst_n), .run(init_q), .ack(ref_ack), .pending(ref_pending)
  );

  sdram_bank_track #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_banks (
    .clk(clk), .rst_n(rst_n), .act(trk_act), .pre_one(trk_pre_one),
    .pre_all(trk_pre_all), .close(trk_close), .ba(cur_bank), .row(cur_row),
    .any_open(any_open), .cur_open(cur_open), .cur_hit(cur_hit)
  );

  sdram_rd_pipe #(.LAT(CAS_LAT)) u_rdpipe (
    .clk(clk), .rst_n(rst_n), .issue(cmd_d == CMD_RD), .strobe(rd_valid)
  );

  assign req_ready = init_q && (state_q == ST_IDLE) && (wait_q == '0) && !ref_pending;

  always_comb begin
    state_d     = state_q;
    wait_d      = (wait_q != '0) ? wait_q - 1'b1 : '0;
    cmd_d       = CMD_NOP;
    ba_d        = '0;
    addr_d      = '0;
    dqm_d       = 1'b0;
    accept      = 1'b0;
    ref_ack     = 1'b0;
    init_set    = 1'b0;
    trk_act     = 1'b0;
    trk_pre_one = 1'b0;
    trk_pre_all = 1'b0;
    trk_close   = 1'b0;
    if (wait_q == '0) begin
      unique case (state_q)
        ST_PWRUP: begin
          cmd_d = CMD_PRE; addr_d[AP_BIT] = 1'b1; trk_pre_all = 1'b1;
          state_d = ST_IREF1; wait_d = WAIT_W'(T_RP - 1);
        end
        ST_IREF1: begin
          cmd_d = CMD_REF; state_d = ST_IREF2; wait_d = WAIT_W'(T_RC - 1);
        end
        ST_IREF2: begin
          cmd_d = CMD_REF; state_d = ST_IMODE; wait_d = WAIT_W'(T_RC - 1);
        end
        ST_IMODE: begin
          cmd_d = CMD_MODE; addr_d = MODE_WORD;
          state_d = ST_IEND; wait_d = WAIT_W'(T_MRD - 1);
        end
        ST_IEND: begin
          init_set = 1'b1; state_d = ST_IDLE;
        end
        ST_IDLE: begin
          if (ref_pending) begin
            if (any_open) begin
              cmd_d = CMD_PRE; addr_d[AP_BIT] = 1'b1; trk_pre_all = 1'b1;
              state_d = ST_REF; wait_d = WAIT_W'(T_RP - 1);
            end else begin
              cmd_d = CMD_REF; ref_ack = 1'b1; wait_d = WAIT_W'(T_RC - 1);
            end
          end else if (req_valid && init_q) begin
            accept = 1'b1;
            if (cur_hit) begin
              cmd_d = cur_write ? CMD_WR : CMD_RD;
              ba_d = cur_bank;
              addr_d[COL_W-1:0] = cur_col;
              addr_d[AP_BIT] = cur_ap;
              dqm_d = cur_write & cur_mask;
              trk_close = cur_ap;
              wait_d = WAIT_W'(COL_GAP - 1);
            end else if (cur_open) begin
              cmd_d = CMD_PRE; ba_d = cur_bank; trk_pre_one = 1'b1;
              state_d = ST_ACT; wait_d = WAIT_W'(T_RP - 1);
            end else begin
              cmd_d = CMD_ACT; ba_d = cur_bank; addr_d = cur_row; trk_act = 1'b1;
              state_d = ST_COL; wait_d = WAIT_W'(T_RCD - 1);
            end
          end
        end
        ST_ACT: begin
          cmd_d = CMD_ACT; ba_d = cur_bank; addr_d = cur_row; trk_act = 1'b1;
          state_d = ST_COL; wait_d = WAIT_W'(T_RCD - 1);
        end
        ST_COL: begin
          cmd_d = cur_write ? CMD_WR : CMD_RD;
          ba_d = cur_bank;
          addr_d[COL_W-1:0] = cur_col;
          addr_d[AP_BIT] = cur_ap;
          dqm_d = cur_write & cur_mask;
          trk_close = cur_ap;
          state_d = ST_IDLE; wait_d = WAIT_W'(COL_GAP - 1);
        end
        ST_REF: begin
          cmd_d = CMD_REF; ref_ack = 1'b1;
          state_d = ST_IDLE; wait_d = WAIT_W'(T_RC - 1);
        end
        default: state_d = ST_PWRUP;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_PWRUP;
      wait_q  <= WAIT_W'(INIT_CYC - 1);
      cmd_q   <= CMD_DESEL;
      ba_q    <= '0;
      addr_q  <= '0;
      dqm_q   <= 1'b0;
      init_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      wait_q  <= wait_d;
      cmd_q   <= cmd_d;
      ba_q    <= ba_d;
      addr_q  <= addr_d;
      dqm_q   <= dqm_d;
      if (init_set) init_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_bank_q <= '0; lat_row_q <= '0; lat_col_q <= '0;
      lat_write_q <= 1'b0; lat_ap_q <= 1'b0; lat_mask_q <= 1'b0;
    end else if (accept) begin
      lat_bank_q <= req_bank; lat_row_q <= req_row; lat_col_q <= req_col;
      lat_write_q <= req_write; lat_ap_q <= req_autopre; lat_mask_q <= req_mask;
    end
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
  assign sd_ba     = ba_q;
  assign sd_addr   = addr_q;
  assign sd_dqm    = dqm_q;
  assign init_done = init_q;
endmodule

// File: rtl/sdram_cmd_ctrl_chk.sv
module sdram_cmd_ctrl_chk
  import sdram_ctrl_pkg::*;
#(
  parameter int CAS_LAT   = 3,
  parameter int BURST_LEN = 4,
  parameter int T_RCD     = 2,
  parameter int T_RP      = 2,
  parameter int T_RC      = 7
) (
  input logic clk,
  input logic rst_n,
  input logic sd_cs_n,
  input logic sd_ras_n,
  input logic sd_cas_n,
  input logic sd_we_n,
  input logic sd_dqm,
  input logic rd_valid,
  input logic req_ready,
  input logic init_done
);
  localparam int GW = 16;
  localparam logic [GW-1:0] GMAX = '1;

  logic [3:0]    cmd, last_q;
  logic [GW-1:0] gap_q;
  logic          is_cmd, is_rd, is_col;

  assign cmd    = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  assign is_cmd = !sd_cs_n && (cmd != CMD_NOP);
  assign is_rd  = (cmd == CMD_RD);
  assign is_col = (cmd == CMD_RD) || (cmd == CMD_WR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_q  <= GMAX;
      last_q <= CMD_NOP;
    end else if (is_cmd) begin
      gap_q  <= 16'd1;
      last_q <= cmd;
    end else if (gap_q != GMAX) begin
      gap_q  <= gap_q + 1'b1;
    end
  end

  AST_ACT_TO_COL: assert property (@(posedge clk) disable iff (!rst_n)
    (is_col && last_q == CMD_ACT) |-> gap_q == GW'(T_RCD)); // R5
  AST_PRE_TO_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_ACT && last_q == CMD_PRE) |-> gap_q == GW'(T_RP)); // R7
  AST_PRE_TO_REF: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_REF && last_q == CMD_PRE) |-> gap_q == GW'(T_RP)); // R8
  AST_REF_RECOVERY: assert property (@(posedge clk) disable iff (!rst_n)
    (is_cmd && last_q == CMD_REF) |-> gap_q >= GW'(T_RC)); // R8
  AST_COL_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (is_cmd && (last_q == CMD_RD || last_q == CMD_WR)) |-> gap_q >= GW'(BURST_LEN + T_RP)); // R12
  AST_RD_STROBE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(is_rd, CAS_LAT)); // R9
  AST_RD_STROBE_DUE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(is_rd, CAS_LAT) |-> rd_valid); // R9
  AST_DQM_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    sd_dqm |-> cmd == CMD_WR); // R11
  AST_READY_AFTER_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> init_done); // R10
  AST_NO_LATE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> cmd != CMD_MODE); // R2
endmodule

bind sdram_cmd_ctrl sdram_cmd_ctrl_chk #(
  .CAS_LAT(CAS_LAT), .BURST_LEN(BURST_LEN), .T_RCD(T_RCD), .T_RP(T_RP), .T_RC(T_RC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
  .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_dqm(sd_dqm), .rd_valid(rd_valid),
  .req_ready(req_ready), .init_done(init_done)
);

// File: tb/sdram_cmd_ctrl_bench.sv
module sdram_cmd_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CAS_LAT = 3, BURST_LEN = 4, T_RCD = 3, T_RP = 2, T_RC = 7, T_MRD = 2;
  localparam int INIT_CYC = 20, REFI = 200;
  localparam int COL_GAP = BURST_LEN + T_RP;
  localparam int REF_BOUND = REFI + T_RP + T_RCD + COL_GAP + T_RP + 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_autopre = 1'b0, req_mask = 1'b0;
  logic [1:0] req_bank = '0;
  logic [11:0] req_row = '0;
  logic [9:0] req_col = '0;
  logic req_ready, rd_valid, init_done, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dqm;
  logic [1:0] sd_ba;
  logic [11:0] sd_addr;

  sdram_cmd_ctrl #(.CAS_LAT(CAS_LAT), .BURST_LEN(BURST_LEN), .T_RCD(T_RCD), .T_RP(T_RP),
    .T_RC(T_RC), .T_MRD(T_MRD), .INIT_CYC(INIT_CYC), .REFI(REFI)) u_sdram_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_autopre(req_autopre), .req_mask(req_mask),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col), .rd_valid(rd_valid),
    .init_done(init_done), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dqm(sd_dqm));

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 1'b0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // expected mode word: CL in bits 6..4, sequential, burst code 2 for length 4
  function automatic logic [11:0] mode_word();
    return {5'b0, 3'(CAS_LAT), 1'b0, 3'd2};
  endfunction

  // accepted-request queue
  logic [1:0]  q_bank [256];
  logic [11:0] q_row  [256];
  logic [9:0]  q_col  [256];
  bit q_wr [256], q_ap [256], q_mk [256];
  int qh = 0, qt = 0;

  // bench bank model
  bit m_open [4];
  logic [11:0] m_row [4];
  int last_act [4], last_pre [4];
  int last_ref = -1000, last_col = -1000, pre_all_cyc = -1000, ref_count = 0;
  int init_step = 0, mode_cyc = 0, rd_due = -1;
  bit init_seen = 1'b0, act_for_head = 1'b0, pre_for_head = 1'b0, expect_ref = 1'b0;

  initial for (int b = 0; b < 4; b++) begin
    m_open[b] = 1'b0; m_row[b] = '0; last_act[b] = -1000; last_pre[b] = -1000;
  end

  always @(negedge clk) begin
    logic [3:0] c;
    c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    if (!rst_n) begin
      chk(sd_cs_n && !req_ready && !init_done && !rd_valid && !sd_dqm, "R1 reset outputs",
          {sd_cs_n, req_ready, init_done, rd_valid, sd_dqm}, 5'b10000);
    end else begin
      if (rd_due == cyc) begin
        chk(rd_valid, "R9 strobe due", rd_valid, 1); rd_due = -1;
      end else if (rd_valid) chk(1'b0, "R9 stray strobe", 1, 0);
      if (init_step == 4 && !init_seen && init_done) begin
        init_seen = 1'b1;
        chk(cyc - mode_cyc == T_MRD, "R2 init_done delay", cyc - mode_cyc, T_MRD);
      end
      if (c != 4'b0111 && c != 4'b1111 && !sd_cs_n) begin
        if (c != 4'b0100 && sd_dqm) chk(1'b0, "R11 dqm off write", 1, 0);
        if (init_step < 4) begin
          case (init_step)
            0: chk(c == 4'b0010 && sd_addr[10], "R2 first precharge-all", c, 4'b0010);
            1: chk(c == 4'b0001 && cyc - pre_all_cyc == T_RP, "R2 first refresh", cyc - pre_all_cyc, T_RP);
            2: chk(c == 4'b0001 && cyc - last_ref == T_RC, "R2 second refresh", cyc - last_ref, T_RC);
            default: begin
              chk(c == 4'b0000 && cyc - last_ref == T_RC, "R2 mode write order", c, 4'b0000);
              chk(sd_addr == mode_word(), "R3 mode word", sd_addr, mode_word());
              mode_cyc = cyc;
            end
          endcase
          if (init_step == 0) pre_all_cyc = cyc;
          if (c == 4'b0001) last_ref = cyc;
          init_step++;
        end else begin
          chk(cyc - last_ref >= T_RC, "R8 refresh recovery", cyc - last_ref, T_RC);
          chk(cyc - last_col >= COL_GAP, "R12 column spacing", cyc - last_col, COL_GAP);
          if (expect_ref && c != 4'b0001) chk(1'b0, "R8 precharge-all not followed by refresh", c, 4'b0001);
          case (c)
            4'b0011: begin
              chk(qh < qt && sd_ba == q_bank[qh] && sd_addr == q_row[qh], "R5 activate target", sd_addr, q_row[qh]);
              chk(!m_open[sd_ba], "R7 activate on open bank", m_open[sd_ba], 0);
              if (pre_for_head) chk(cyc - last_pre[sd_ba] == T_RP, "R7 precharge to activate", cyc - last_pre[sd_ba], T_RP);
              else chk(cyc - last_pre[sd_ba] >= T_RP, "R7 precharge recovery", cyc - last_pre[sd_ba], T_RP);
              m_open[sd_ba] = 1'b1; m_row[sd_ba] = sd_addr; last_act[sd_ba] = cyc; act_for_head = 1'b1;
            end
            4'b0010: begin
              if (sd_addr[10]) begin
                for (int b = 0; b < 4; b++) begin m_open[b] = 1'b0; last_pre[b] = cyc; end
                pre_all_cyc = cyc; expect_ref = 1'b1;
              end else begin
                chk(qh < qt && sd_ba == q_bank[qh] && m_open[sd_ba] && m_row[sd_ba] != q_row[qh],
                    "R7 single precharge only on row miss", m_row[sd_ba], q_row[qh]);
                m_open[sd_ba] = 1'b0; last_pre[sd_ba] = cyc; pre_for_head = 1'b1;
              end
            end
            4'b0001: begin
              bit anyo;
              anyo = m_open[0] | m_open[1] | m_open[2] | m_open[3];
              chk(!anyo, "R8 refresh with open bank", anyo, 0);
              if (expect_ref) chk(cyc - pre_all_cyc == T_RP, "R8 precharge-all to refresh", cyc - pre_all_cyc, T_RP);
              if (ref_count > 0) chk(cyc - last_ref <= REF_BOUND, "R8 refresh interval", cyc - last_ref, REF_BOUND);
              expect_ref = 1'b0; last_ref = cyc; ref_count++;
            end
            4'b0101, 4'b0100: begin
              bit w;
              w = (c == 4'b0100);
              chk(qh < qt, "R10 column with no request", qt - qh, 1);
              if (qh < qt) begin
                chk(sd_ba == q_bank[qh] && sd_addr[9:0] == q_col[qh] && !sd_addr[11],
                    "R5 column address", sd_addr, {1'b0, q_ap[qh], q_col[qh]});
                chk(sd_addr[10] == q_ap[qh] && w == q_wr[qh], "R5 column flags", {sd_addr[10], w}, {q_ap[qh], q_wr[qh]});
                chk(m_open[sd_ba] && m_row[sd_ba] == q_row[qh], "R6 column on right row", m_row[sd_ba], q_row[qh]);
                if (act_for_head) chk(cyc - last_act[sd_ba] == T_RCD, "R5 activate to column", cyc - last_act[sd_ba], T_RCD);
                chk(sd_dqm == (w & q_mk[qh]), "R11 write mask", sd_dqm, w & q_mk[qh]);
                if (q_ap[qh]) begin m_open[sd_ba] = 1'b0; last_pre[sd_ba] = cyc + BURST_LEN; end
                qh++;
              end
              if (!w) rd_due = cyc + CAS_LAT;
              last_col = cyc; act_for_head = 1'b0; pre_for_head = 1'b0;
            end
            default: chk(1'b0, "R4 unexpected command code", c, 4'b0111);
          endcase
        end
      end
    end
  end

  task automatic send(input logic [1:0] b, input logic [11:0] r, input logic [9:0] col,
                      input bit w, input bit ap, input bit mk);
    @(negedge clk);
    req_valid = 1'b1; req_bank = b; req_row = r; req_col = col;
    req_write = w; req_autopre = ap; req_mask = mk;
    while (!req_ready) @(negedge clk);
    q_bank[qt] = b; q_row[qt] = r; q_col[qt] = col; q_wr[qt] = w; q_ap[qt] = ap; q_mk[qt] = mk;
    qt++;
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    @(negedge clk); req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [11:0] pool [3];
    int hit_col;
    void'($urandom(32'h5D3A));
    pool[0] = 12'h005; pool[1] = 12'hA3C; pool[2] = 12'hFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10: request held before initialisation is not taken
    @(negedge clk); req_valid = 1'b1;
    repeat (5) begin
      @(negedge clk);
      if (!init_done) chk(!req_ready, "R10 ready before init", req_ready, 0);
    end
    req_valid = 1'b0;
    while (!init_done) @(negedge clk);
    // directed: closed bank, row hit, row miss, auto-precharge, then reopen
    send(2'd0, 12'h005, 10'h009, 1'b0, 1'b0, 1'b0);  // R5
    send(2'd0, 12'h005, 10'h3FF, 1'b0, 1'b0, 1'b0);  // R6
    hit_col = ref_count;
    send(2'd0, 12'hA3C, 10'h000, 1'b1, 1'b0, 1'b1);  // R7, R11
    send(2'd1, 12'hFFF, 10'h155, 1'b1, 1'b1, 1'b0);  // R5 with auto-precharge
    send(2'd1, 12'hFFF, 10'h2AA, 1'b0, 1'b1, 1'b0);  // reopen after auto-precharge
    idle(30);
    // random back-to-back traffic, colliding with refresh requests (R8)
    for (int i = 0; i < 150; i++)
      send(2'($urandom % 4), pool[$urandom % 3], 10'($urandom), 1'($urandom),
           ($urandom % 4) == 0, 1'($urandom));
    idle(3 * REFI);
    chk(qh == qt, "R10 every request served", qh, qt);
    chk(ref_count >= 8, "R8 refresh count", ref_count, 8);
    chk(hit_col >= 0, "R6 directed sequence ran", hit_col, 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", qh, qt);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule